// File: doc/BRIEF.md
# Barrel Shifter with Carry-Out

This block shifts a 32-bit operand by a variable count in one of four ways: logical left, logical right, arithmetic right, or rotate right. Along with the shifted word it produces a shifter carry-out, which is the last bit moved out of the word. The count comes from one of two places. It is either a 5-bit immediate, or the low byte of a 32-bit count register. Counts of 32 and above are only possible from the register source. For those counts each operation gives a defined saturated word and follows its own carry rule.

When the effective count is zero, the operand passes through unchanged and the incoming carry is forwarded. A datapath can therefore always take the carry from this block, whether or not the operation defined a new one. Every request presented with `in_valid` gives its result one clock later, from registers.

Top module: `barrel_shifter`

## Requirements
- R1: The effective count depends on `use_reg_amt`. When it is 1, the count is `reg_amt[7:0]` and bits 31:8 are ignored. When it is 0, the count is `imm_amt` (0..31) and `reg_amt` is ignored.
- R2: An effective count of zero returns the operand unchanged and sets `carry_out` equal to `carry_in`, for every operation.
- R3: With `op`=00 (left logical) and count n in 1..31, the result is the operand shifted left by n with zeros entering. The carry is operand bit 32-n.
- R4: With `op`=01 (right logical) and n in 1..31, the result is the operand shifted right by n with zeros entering. The carry is operand bit n-1.
- R5: With `op`=10 (right arithmetic) and n in 1..31, the result is the operand shifted right by n with copies of bit 31 entering. The carry is operand bit n-1.
- R6: With `op`=11 (rotate right), the rotate count k is the low 5 bits of the count. When k is nonzero, the result is the operand rotated right by k and the carry is operand bit k-1.
- R7: For left logical with a count of exactly 32, the result is zero and the carry is operand bit 0. With a count above 32, both the result and the carry are zero.
- R8: For right logical with a count of exactly 32, the result is zero and the carry is operand bit 31. With a count above 32, both the result and the carry are zero.
- R9: For right arithmetic with a count of 32 or more, every result bit equals operand bit 31, and the carry is operand bit 31.
- R10: For rotate with a nonzero count whose low 5 bits are zero, the result is the unchanged operand and the carry is operand bit 31.
- R11: `out_valid`, `result` and `carry_out` reflect the request accepted on the previous clock edge. A synchronous reset clears all three to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present this cycle |
| op | input | 2 | 00 left logical, 01 right logical, 10 right arithmetic, 11 rotate right |
| operand | input | 32 | Word to shift |
| use_reg_amt | input | 1 | 1: count from register low byte, 0: count from immediate |
| imm_amt | input | 5 | Immediate count |
| reg_amt | input | 32 | Count register; only bits 7:0 are used |
| carry_in | input | 1 | Carry forwarded when the count is zero |
| out_valid | output | 1 | Registered result valid |
| result | output | 32 | Shifted word |
| carry_out | output | 1 | Shifter carry |

## Verification
For every operation, the register count is swept over all 256 values. This is done against operands with the sign bit set and clear, plus alternating-bit and random words. The sweep separates the in-range cases (R3 to R6) from the exact-32 cases, the above-32 cases, and the rotate wrap at 32, 64 and so on, where the carry rules diverge. Random upper count bits (R1) show that only the low byte matters. A second sweep uses immediate counts 0..31 with a garbage count register, and checks that source select and zero-count carry forwarding (R2) are independent of the register. Idle cycles are mixed in, so `out_valid` is compared on cycles without a request as well as with one.

// File: rtl/barrel_pkg.sv
package barrel_pkg;

    localparam int WORD_W = 32;
    localparam int AMT_W  = 8;
    localparam int CNT_W  = $clog2(WORD_W);

    typedef enum logic [1:0] {
        SH_LSL = 2'b00,
        SH_LSR = 2'b01,
        SH_ASR = 2'b10,
        SH_ROR = 2'b11
    } shift_op_e;

    typedef struct packed {
        logic             zero;   // effective count is zero
        logic             over;   // effective count >= WORD_W
        logic             exact;  // effective count == WORD_W
        logic [CNT_W-1:0] cnt;    // count modulo WORD_W
    } amt_info_t;

    typedef struct packed {
        logic [WORD_W-1:0] value;
        logic              carry;
    } shift_rsp_t;

    function automatic logic [WORD_W-1:0] bit_flip(input logic [WORD_W-1:0] w);
        logic [WORD_W-1:0] r;
        for (int i = 0; i < WORD_W; i++) begin
            r[i] = w[WORD_W-1-i];
        end
        return r;
    endfunction

endpackage

// File: rtl/barrel_amt_sel.sv
module barrel_amt_sel
    import barrel_pkg::*;
#(
    parameter int DW = WORD_W,
    parameter int AW = AMT_W,
    parameter int CW = CNT_W
) (
    input  logic          use_reg,
    input  logic [CW-1:0] imm,
    input  logic [DW-1:0] reg_word,
    output amt_info_t     info
);
    logic [AW-1:0] eff;
    logic          unused_hi;

    assign unused_hi = ^reg_word[DW-1:AW];

    always_comb begin
        eff        = use_reg ? reg_word[AW-1:0] : AW'(imm);
        info.zero  = (eff == '0);
        info.over  = |eff[AW-1:CW];
        info.exact = (eff == AW'(DW));
        info.cnt   = eff[CW-1:0];
    end
endmodule

// File: rtl/barrel_rshift_net.sv
module barrel_rshift_net
    import barrel_pkg::*;
#(
    parameter int DW = WORD_W,
    parameter int CW = CNT_W
) (
    input  shift_op_e     op,
    input  logic [DW-1:0] din,
    input  logic [CW-1:0] cnt,
    output logic [DW-1:0] dout
);
    logic [DW-1:0] stage [CW+1];
    logic          fill;
    logic          is_rot;

    assign is_rot   = (op == SH_ROR);
    assign fill     = (op == SH_ASR) ? din[DW-1] : 1'b0;
    assign stage[0] = (op == SH_LSL) ? bit_flip(din) : din;

    for (genvar s = 0; s < CW; s++) begin : g_stage
        localparam int SH = 1 << s;
        logic [DW-1:0] moved;
        always_comb begin
            if (is_rot) begin
                moved = {stage[s][SH-1:0], stage[s][DW-1:SH]};
            end else begin
                moved = {{SH{fill}}, stage[s][DW-1:SH]};
            end
        end
        assign stage[s+1] = cnt[s] ? moved : stage[s];
    end

    assign dout = (op == SH_LSL) ? bit_flip(stage[CW]) : stage[CW];
endmodule

// File: rtl/barrel_fixup.sv
module barrel_fixup
    import barrel_pkg::*;
#(
    parameter int DW = WORD_W,
    parameter int CW = CNT_W
) (
    input  shift_op_e     op,
    input  logic [DW-1:0] din,
    input  logic [DW-1:0] shifted,
    input  amt_info_t     info,
    input  logic          cin,
    output shift_rsp_t    rsp
);
    logic [CW-1:0] left_idx;
    logic [CW-1:0] right_idx;
    logic          sign;

    assign left_idx  = ~info.cnt + 1'b1;  // DW - cnt
    assign right_idx = info.cnt - 1'b1;
    assign sign      = din[DW-1];

    always_comb begin
        rsp.value = shifted;
        rsp.carry = din[right_idx];
        if (info.zero) begin
            rsp.value = din;
            rsp.carry = cin;
        end else begin
            unique case (op)
                SH_LSL: begin
                    if (info.over) begin
                        rsp.value = '0;
                        rsp.carry = info.exact & din[0];
                    end else begin
                        rsp.carry = din[left_idx];
                    end
                end
                SH_LSR: begin
                    if (info.over) begin
                        rsp.value = '0;
                        rsp.carry = info.exact & sign;
                    end
                end
                SH_ASR: begin
                    if (info.over) begin
                        rsp.value = {DW{sign}};
                        rsp.carry = sign;
                    end
                end
                SH_ROR: begin
                    if (info.cnt == '0) begin
                        rsp.value = din;
                        rsp.carry = sign;
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/barrel_shifter.sv
module barrel_shifter
    import barrel_pkg::*;
#(
    parameter int DW = WORD_W,
    parameter int AW = AMT_W,
    localparam int CW = $clog2(DW)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic [1:0]    op,
    input  logic [DW-1:0] operand,
    input  logic          use_reg_amt,
    input  logic [CW-1:0] imm_amt,
    input  logic [DW-1:0] reg_amt,
    input  logic          carry_in,
    output logic          out_valid,
    output logic [DW-1:0] result,
    output logic          carry_out
);
    shift_op_e     op_e;
    amt_info_t     info;
    logic [DW-1:0] shifted;
    shift_rsp_t    rsp;

    assign op_e = shift_op_e'(op);

    barrel_amt_sel #(.DW(DW), .AW(AW), .CW(CW)) u_amt (
        .use_reg  (use_reg_amt),
        .imm      (imm_amt),
        .reg_word (reg_amt),
        .info     (info)
    );

    barrel_rshift_net #(.DW(DW), .CW(CW)) u_net (
        .op   (op_e),
        .din  (operand),
        .cnt  (info.cnt),
        .dout (shifted)
    );

    barrel_fixup #(.DW(DW), .CW(CW)) u_fix (
        .op      (op_e),
        .din     (operand),
        .shifted (shifted),
        .info    (info),
        .cin     (carry_in),
        .rsp     (rsp)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            result    <= '0;
            carry_out <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                result    <= rsp.value;
                carry_out <= rsp.carry;
            end
        end
    end
endmodule

// File: rtl/barrel_shifter_chk.sv
module barrel_shifter_chk #(
    parameter int DW = 32,
    parameter int AW = 8,
    parameter int CW = 5
) (
    input logic          clk,
    input logic          rst,
    input logic          in_valid,
    input logic [1:0]    op,
    input logic [DW-1:0] operand,
    input logic          use_reg_amt,
    input logic [CW-1:0] imm_amt,
    input logic [DW-1:0] reg_amt,
    input logic          carry_in,
    input logic          out_valid,
    input logic [DW-1:0] result,
    input logic          carry_out
);
    logic          primed;
    logic [AW-1:0] eff;

    assign eff = use_reg_amt ? reg_amt[AW-1:0] : AW'(imm_amt);

    always_ff @(posedge clk) begin
        if (rst) primed <= 1'b0;
        else     primed <= 1'b1;
    end

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (!out_valid && result == '0 && !carry_out)); // R11

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
        primed |=> (out_valid == $past(in_valid))); // R11

    AST_ZERO_KEEP: assert property (@(posedge clk) disable iff (rst)
        (primed && in_valid && eff == '0)
        |=> (result == $past(operand) && carry_out == $past(carry_in))); // R2

    AST_LSL_BEYOND: assert property (@(posedge clk) disable iff (rst)
        (primed && in_valid && op == 2'b00 && eff > AW'(DW))
        |=> (result == '0 && !carry_out)); // R7

    AST_LSR_BEYOND: assert property (@(posedge clk) disable iff (rst)
        (primed && in_valid && op == 2'b01 && eff > AW'(DW))
        |=> (result == '0 && !carry_out)); // R8

    AST_ASR_SATURATE: assert property (@(posedge clk) disable iff (rst)
        (primed && in_valid && op == 2'b10 && eff >= AW'(DW))
        |=> (result == {DW{$past(operand[DW-1])}} && carry_out == $past(operand[DW-1]))); // R9

    AST_ROR_WRAP: assert property (@(posedge clk) disable iff (rst)
        (primed && in_valid && op == 2'b11 && eff != '0 && eff[CW-1:0] == '0)
        |=> (result == $past(operand) && carry_out == $past(operand[DW-1]))); // R10
endmodule

bind barrel_shifter barrel_shifter_chk #(.DW(DW), .AW(AW), .CW(CW)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .op          (op),
    .operand     (operand),
    .use_reg_amt (use_reg_amt),
    .imm_amt     (imm_amt),
    .reg_amt     (reg_amt),
    .carry_in    (carry_in),
    .out_valid   (out_valid),
    .result      (result),
    .carry_out   (carry_out)
);

// File: tb/barrel_shifter_bench.sv
`timescale 1ns/1ps
module barrel_shifter_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [1:0]  op = 2'b00;
    logic [31:0] operand = '0;
    logic        use_reg_amt = 1'b0;
    logic [4:0]  imm_amt = '0;
    logic [31:0] reg_amt = '0;
    logic        carry_in = 1'b0;
    logic        out_valid;
    logic [31:0] result;
    logic        carry_out;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    logic        pend_valid = 1'b0;
    logic [31:0] pend_res   = '0;
    logic        pend_c     = 1'b0;
    string       pend_tag   = "R11";

    always #2 clk = ~clk;

    barrel_shifter u_barrel_shifter (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .operand(operand),
        .use_reg_amt(use_reg_amt), .imm_amt(imm_amt), .reg_amt(reg_amt),
        .carry_in(carry_in), .out_valid(out_valid), .result(result),
        .carry_out(carry_out)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 50000) begin
            fails++;
            $display("FAIL watchdog expired: actual cycles=%0d expected<=50000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    function automatic string tag_of(input logic [1:0] o, input int n);
        if (n == 0) return "R2";
        case (o)
            2'b00: return (n < 32) ? "R3" : "R7";
            2'b01: return (n < 32) ? "R4" : "R8";
            2'b10: return (n < 32) ? "R5" : "R9";
            default: return ((n % 32) != 0) ? "R6" : "R10";
        endcase
    endfunction

    // Behavioural model on a wide vector: the carry is the last bit shifted out.
    task automatic model(input logic [1:0] o, input logic [31:0] x, input int n,
                         input logic cin, output logic [31:0] r, output logic c);
        logic [287:0] ext;
        logic [287:0] sh;
        logic [63:0]  dbl;
        int k;
        if (n == 0) begin
            r = x; c = cin;
        end else begin
            case (o)
                2'b00: begin
                    ext = {256'b0, x};
                    sh  = ext << n;
                    r   = sh[31:0];
                    c   = sh[32];
                end
                2'b01: begin
                    ext = {256'b0, x};
                    sh  = ext >> n;
                    r   = sh[31:0];
                    c   = ext[n-1];
                end
                2'b10: begin
                    ext = {{256{x[31]}}, x};
                    sh  = ext >> n;
                    r   = sh[31:0];
                    c   = ext[n-1];
                end
                default: begin
                    k = n % 32;
                    if (k == 0) begin
                        r = x; c = x[31];
                    end else begin
                        dbl = {x, x} >> k;
                        r   = dbl[31:0];
                        c   = x[k-1];
                    end
                end
            endcase
        end
    endtask

    task automatic check_outputs();
        checks++;
        if (out_valid !== pend_valid) begin
            fails++;
            $display("FAIL R11 out_valid: actual=%0b expected=%0b", out_valid, pend_valid);
        end
        if (pend_valid) begin
            checks++;
            if (result !== pend_res || carry_out !== pend_c) begin
                fails++;
                $display("FAIL %s result/carry: actual=%h/%0b expected=%h/%0b",
                         pend_tag, result, carry_out, pend_res, pend_c);
            end
        end
    endtask

    // Called just after a negedge: check the previous request, drive the next.
    task automatic step(input logic v, input logic [1:0] o, input logic [31:0] x,
                        input logic src, input logic [4:0] imm, input logic [31:0] ra,
                        input logic cin);
        logic [31:0] er;
        logic        ec;
        int          n;
        check_outputs();
        in_valid = v; op = o; operand = x; use_reg_amt = src;
        imm_amt = imm; reg_amt = ra; carry_in = cin;
        n = src ? int'(ra[7:0]) : int'(imm);
        model(o, x, n, cin, er, ec);
        pend_valid = v; pend_res = er; pend_c = ec;
        pend_tag = src ? tag_of(o, n) : ((n == 0) ? "R2" : "R1");
        @(negedge clk);
    endtask

    initial begin
        logic [31:0] pats [4];
        pats[0] = 32'h8000_0001;
        pats[1] = 32'h7F3C_5A96;
        pats[2] = 32'hAAAA_5555;
        pats[3] = $urandom;

        // Reset, with a request held during reset that must not appear (R11)
        in_valid = 1'b1; operand = 32'hFFFF_FFFF; reg_amt = 32'd3; use_reg_amt = 1'b1;
        repeat (3) @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || result !== '0 || carry_out !== 1'b0) begin
            fails++;
            $display("FAIL R11 reset state: actual=%0b/%h/%0b expected=0/00000000/0",
                     out_valid, result, carry_out);
        end
        in_valid = 1'b0;
        rst = 1'b0;
        @(negedge clk);

        // Register-count sweep, random upper count bits (R1, R2..R10)
        for (int o = 0; o < 4; o++) begin
            for (int p = 0; p < 4; p++) begin
                for (int n = 0; n < 256; n++) begin
                    logic [31:0] ra;
                    ra = {$urandom(), 8'h00} | 32'(n);
                    step(1'b1, 2'(o), pats[p], 1'b1, 5'($urandom), ra, 1'(n + p));
                    if ((n % 37) == 5)
                        step(1'b0, 2'(o), $urandom, 1'b1, '0, '0, 1'b0);
                end
            end
        end

        // Immediate-count sweep with a garbage count register (R1, R2)
        for (int o = 0; o < 4; o++) begin
            for (int p = 0; p < 4; p++) begin
                for (int n = 0; n < 32; n++) begin
                    step(1'b1, 2'(o), pats[p], 1'b0, 5'(n), 32'hFFFF_FF20 | $urandom, 1'(n));
                end
            end
        end

        step(1'b0, 2'b00, '0, 1'b0, '0, '0, 1'b0);
        check_outputs();

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule